// File: doc/BRIEF.md
# Calibration Trim DAC Serial Loader

This block takes a single calibration write request and delivers it over a two-wire serial link to a bank of three 8-channel, 8-bit trim DACs. A request carries a channel number from 0 to 20 and an 8-bit trim code. The block builds an 11-bit word from the low three channel bits, which act as the address inside a chip, and the trim code. It shifts the word out on a data line and a clock line. It then pulses a 2-bit encoded load-select bus that names the chip owning the channel.

Requests use a valid/ready handshake. One request is in flight at a time, and a request presented while the block is busy waits until the block is idle. Channel numbers outside the bank are taken and discarded, and an error pulse reports them. The length of each serial clock phase is set by an input measured in system cycles. The block also keeps a copy of the last code written to each channel, which can be read at any time through a combinational read port.

Top module: `trim_dac_loader`

## Requirements
- R1: Each accepted in-range request produces exactly 11 rising edges of `ser_clk`. The 11 data bits, taken in order, form the word {chan[2:0], value[7:0]}, sent most-significant bit first.
- R2: `ser_data` changes only while `ser_clk` is low, and it holds its value for the whole of every high phase.
- R3: Every low phase, every high phase and the load pulse each last max(`phase_len`, 1) system cycles. The value is latched when the request is accepted.
- R4: After the 11th high phase ends, `load_sel` shows (chan >> 3) + 1 for one pulse and then returns to 0. That is 1 for channels 0 to 7, 2 for channels 8 to 15 and 3 for channels 16 to 20. `load_sel` is 0 at all other times.
- R5: A request with a channel of 21 or more is accepted while `req_ready` stays high. It causes no `ser_clk` or `load_sel` activity and leaves the readback unchanged. `bad_chan` is high for the one cycle after acceptance.
- R6: `req_ready` is low from the cycle after an in-range request is accepted until `load_sel` has returned to 0, which is 23 × max(`phase_len`, 1) cycles. A request held while `req_ready` is low is taken only after that.
- R7: The readback returns 0 for every channel after reset. It takes the new code only when a frame completes. `rb_val` is 0 for `rb_chan` of 21 or more.
- R8: During and after reset, `ser_clk`, `ser_data`, `load_sel` and `bad_chan` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_len | input | 8 | Cycles per serial clock phase and per load pulse (0 behaves as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_chan | input | 5 | Calibration channel number |
| req_val | input | 8 | Trim code |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock line |
| load_sel | output | 2 | Encoded load strobe (0 = none, 1..3 = chip) |
| bad_chan | output | 1 | One-cycle pulse for a discarded out-of-range request |
| rb_chan | input | 5 | Readback channel select |
| rb_val | output | 8 | Last code written to `rb_chan` |

## Verification
Frames are sent to channels at both ends of each chip's range: 0, 7, 8, 15, 16 and 20. The trim codes mix alternating, all-ones, single-bit and zero patterns, so a swapped field, a reversed bit order or a wrong chip code each produces a different received word or strobe value. The phase length is varied over 0, 1, 2 and 3, which separates a fixed-width timer from one that follows the input, and shows whether 0 is clamped to 1. Out-of-range channels 21 and 31 check that a discarded request leaves both the wires and the readback untouched. A request held across a busy frame checks that a waiting request is taken only once, and only after the strobe ends.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2,
      ST_LOAD = 2'd3
   } tdl_state_e;
endpackage

// File: rtl/tdl_phase_timer.sv
module tdl_phase_timer #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [LEN_W-1:0] len,
   output logic             last
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] len_eff;

   assign len_eff = (len == '0) ? ONE : len;
   assign last    = (cnt == len_eff - ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (restart || last) cnt <= '0;
      else                     cnt <= cnt + ONE;
   end

   // R3: the phase counter never runs past the programmed length
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> (cnt < len_eff));
endmodule

// File: rtl/tdl_serializer.sv
module tdl_serializer
   import tdl_pkg::*;
#(
   parameter int CHAN_W = 5,
   parameter int VAL_W  = 8,
   parameter int SUB_W  = 3,
   parameter int SEL_W  = 2,
   parameter int NUM_CH = 21,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CHAN_W-1:0] req_chan,
   input  logic [VAL_W-1:0]  req_val,
   input  logic [LEN_W-1:0]  phase_len,
   output logic              req_ready,
   output logic              ser_data,
   output logic              ser_clk,
   output logic [SEL_W-1:0]  load_sel,
   output logic              bad_chan,
   output logic              done,
   output logic [CHAN_W-1:0] done_chan,
   output logic [VAL_W-1:0]  done_val
);
   localparam int FRAME_W = SUB_W + VAL_W;
   localparam int CNT_W   = $clog2(FRAME_W);
   localparam int NUM_DEV = ((NUM_CH - 1) >> SUB_W) + 1;
   localparam logic [CHAN_W-1:0] CH_LIM = CHAN_W'(NUM_CH);

   generate
      if (NUM_CH > (1 << CHAN_W)) begin : g_chk_chan
         $error("NUM_CH does not fit in CHAN_W bits");
      end
      if (NUM_DEV >= (1 << SEL_W)) begin : g_chk_sel
         $error("SEL_W too narrow for the chip count plus the idle code");
      end
   endgenerate

   tdl_state_e        state;
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]  bits_left;
   logic [SEL_W-1:0]  sel_q;
   logic [CHAN_W-1:0] chan_q;
   logic [VAL_W-1:0]  val_q;
   logic [LEN_W-1:0]  len_q;
   logic              accept;
   logic              in_range;
   logic              ph_last;
   logic [SEL_W-1:0]  sel_next;

   assign accept   = req_valid && (state == ST_IDLE);
   assign in_range = (req_chan < CH_LIM);
   assign sel_next = SEL_W'(req_chan >> SUB_W) + SEL_W'(1);

   tdl_phase_timer #(.LEN_W(LEN_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (state == ST_IDLE),
      .len     (len_q),
      .last    (ph_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         bits_left <= '0;
         sel_q     <= '0;
         chan_q    <= '0;
         val_q     <= '0;
         len_q     <= '0;
         bad_chan  <= 1'b0;
      end else begin
         bad_chan <= 1'b0;
         unique case (state)
            ST_IDLE: if (accept) begin
               if (in_range) begin
                  shreg     <= {req_chan[SUB_W-1:0], req_val};
                  bits_left <= CNT_W'(FRAME_W - 1);
                  sel_q     <= sel_next;
                  chan_q    <= req_chan;
                  val_q     <= req_val;
                  len_q     <= phase_len;
                  state     <= ST_LOW;
               end else begin
                  bad_chan <= 1'b1;
               end
            end
            ST_LOW: if (ph_last) state <= ST_HIGH;
            ST_HIGH: if (ph_last) begin
               if (bits_left == '0) begin
                  state <= ST_LOAD;
               end else begin
                  shreg     <= shreg << 1;
                  bits_left <= bits_left - CNT_W'(1);
                  state     <= ST_LOW;
               end
            end
            ST_LOAD: if (ph_last) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign ser_clk   = (state == ST_HIGH);
   assign ser_data  = ((state == ST_LOW) || (state == ST_HIGH)) && shreg[FRAME_W-1];
   assign load_sel  = (state == ST_LOAD) ? sel_q : '0;
   assign done      = (state == ST_LOAD) && ph_last;
   assign done_chan = chan_q;
   assign done_val  = val_q;

   // R2: data held steady across a high phase
   a_r2_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
   // R4: the load strobe never overlaps a clock high phase
   a_r4_strobe_no_clk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_sel != '0) |-> !ser_clk);
   // R6: the block is not ready while a strobe is out
   a_r6_busy_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (load_sel != '0) |-> !req_ready);
   // R5: a discard pulse comes with quiet serial lines
   a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      bad_chan |-> (!ser_clk && (load_sel == '0)));
endmodule

// File: rtl/tdl_readback.sv
module tdl_readback #(
   parameter int NUM_CH = 21,
   parameter int CHAN_W = 5,
   parameter int VAL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CHAN_W-1:0] wr_chan,
   input  logic [VAL_W-1:0]  wr_val,
   input  logic [CHAN_W-1:0] rd_chan,
   output logic [VAL_W-1:0]  rd_val
);
   localparam logic [CHAN_W-1:0] CH_LIM = CHAN_W'(NUM_CH);

   logic [VAL_W-1:0] mem [NUM_CH];
   logic [NUM_CH-1:0] hit;

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_cell
         assign hit[g] = wr && (wr_chan == CHAN_W'(g));
         always_ff @(posedge clk) begin
            if (!rst_n)      mem[g] <= '0;
            else if (hit[g]) mem[g] <= wr_val;
         end
      end
   endgenerate

   assign rd_val = (rd_chan < CH_LIM) ? mem[rd_chan] : '0;

   // R7: at most one cell is written per cycle
   a_r7_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
   // R7: with no write, a steady address reads a steady value
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> (!$stable(rd_chan) || $stable(rd_val)));
endmodule

// File: rtl/trim_dac_loader.sv
module trim_dac_loader #(
   parameter int CHAN_W = 5,
   parameter int VAL_W  = 8,
   parameter int SUB_W  = 3,
   parameter int SEL_W  = 2,
   parameter int NUM_CH = 21,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  phase_len,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CHAN_W-1:0] req_chan,
   input  logic [VAL_W-1:0]  req_val,
   output logic              ser_data,
   output logic              ser_clk,
   output logic [SEL_W-1:0]  load_sel,
   output logic              bad_chan,
   input  logic [CHAN_W-1:0] rb_chan,
   output logic [VAL_W-1:0]  rb_val
);
   logic              done;
   logic [CHAN_W-1:0] done_chan;
   logic [VAL_W-1:0]  done_val;

   tdl_serializer #(
      .CHAN_W(CHAN_W), .VAL_W(VAL_W), .SUB_W(SUB_W),
      .SEL_W(SEL_W), .NUM_CH(NUM_CH), .LEN_W(LEN_W)
   ) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_chan  (req_chan),
      .req_val   (req_val),
      .phase_len (phase_len),
      .req_ready (req_ready),
      .ser_data  (ser_data),
      .ser_clk   (ser_clk),
      .load_sel  (load_sel),
      .bad_chan  (bad_chan),
      .done      (done),
      .done_chan (done_chan),
      .done_val  (done_val)
   );

   tdl_readback #(
      .NUM_CH(NUM_CH), .CHAN_W(CHAN_W), .VAL_W(VAL_W)
   ) u_rb (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (done),
      .wr_chan (done_chan),
      .wr_val  (done_val),
      .rd_chan (rb_chan),
      .rd_val  (rb_val)
   );

   // R5: a discarded request leaves the strobe bus idle next cycle too
   a_r5_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      bad_chan |=> (load_sel == '0));
endmodule

// File: tb/sim_trim_dac_loader.sv
module sim_trim_dac_loader;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] phase_len = 8'd1;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [4:0] req_chan = '0;
   logic [7:0] req_val = '0;
   logic       ser_data, ser_clk, bad_chan;
   logic [1:0] load_sel;
   logic [4:0] rb_chan = '0;
   logic [7:0] rb_val;

   int total = 0;
   int bad = 0;

   trim_dac_loader u0 (
      .clk(clk), .rst_n(rst_n), .phase_len(phase_len),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_chan(req_chan), .req_val(req_val),
      .ser_data(ser_data), .ser_clk(ser_clk), .load_sel(load_sel),
      .bad_chan(bad_chan), .rb_chan(rb_chan), .rb_val(rb_val)
   );

   always #10 clk = ~clk;

   // serial receiver model
   int         exp_len = 1;
   int         run = 0;
   int         rises = 0;
   int         rx_bits = 0;
   logic [10:0] rx_shift = '0;
   int         width_err = 0;
   int         stab_err = 0;
   int         strobes = 0;
   logic [10:0] frame_a = '0, frame_b = '0;
   int         bits_a = 0;
   logic [1:0] sel_a = '0, sel_b = '0;
   logic       pclk = 1'b0, pdata = 1'b0, pready = 1'b1;
   logic [1:0] psel = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ser_clk && pclk && (ser_data != pdata)) stab_err++;
         if (ser_clk && !pclk) begin
            rises++;
            rx_bits++;
            rx_shift = {rx_shift[9:0], ser_data};
         end
         if (load_sel != 2'd0 && psel == 2'd0) begin
            strobes++;
            frame_b = frame_a; sel_b = sel_a;
            frame_a = rx_shift; sel_a = load_sel; bits_a = rx_bits;
         end
         if (pready && !req_ready) begin
            run = 1;
            rx_bits = 0;
         end else if ((ser_clk != pclk) || (load_sel != psel)) begin
            if (!pready && run != exp_len) width_err++;
            run = 1;
         end else begin
            run++;
         end
      end
      pclk = ser_clk; pdata = ser_data; pready = req_ready; psel = load_sel;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic read_rb(input int ch, output int v);
      @(negedge clk);
      rb_chan = 5'(ch);
      #1 v = int'(rb_val);
   endtask

   // drive one request; returns at the negedge after acceptance
   task automatic send(input int ch, input int val);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_chan = 5'(ch); req_val = 8'(val);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      int v;
      chk(req_ready === 1'b1, "R8", "ready", int'(req_ready), 1);
      chk(ser_clk === 1'b0 && ser_data === 1'b0, "R8", "serial idle",
          int'({ser_clk, ser_data}), 0);
      chk(load_sel === 2'd0 && bad_chan === 1'b0, "R8", "strobe/err idle",
          int'({load_sel, bad_chan}), 0);
      for (int c = 0; c < 21; c++) begin
         read_rb(c, v);
         chk(v == 0, "R7", "readback after reset", v, 0);
      end
   endtask

   task automatic t_frame(input int ch, input int val, input int len);
      int busy;
      int v;
      int s0;
      phase_len = 8'(len);
      exp_len = (len == 0) ? 1 : len;
      s0 = strobes;
      width_err = 0; stab_err = 0;
      send(ch, val);
      busy = 0;
      while (!req_ready) begin busy++; @(negedge clk); end
      chk(strobes == s0 + 1, "R4", "one strobe", strobes - s0, 1);
      chk(bits_a == 11, "R1", "clock edges per frame", bits_a, 11);
      chk(frame_a == {3'(ch), 8'(val)}, "R1", "received word",
          int'(frame_a), int'({3'(ch), 8'(val)}));
      chk(sel_a == 2'((ch >> 3) + 1), "R4", "load_sel code",
          int'(sel_a), (ch >> 3) + 1);
      chk(load_sel == 2'd0, "R4", "strobe released", int'(load_sel), 0);
      chk(width_err == 0, "R3", "phase widths", width_err, 0);
      chk(stab_err == 0, "R2", "data stable in high", stab_err, 0);
      chk(busy == 23 * exp_len, "R6", "busy length", busy, 23 * exp_len);
      read_rb(ch, v);
      chk(v == val, "R7", "readback updated", v, val);
   endtask

   task automatic t_bad(input int ch);
      int r0, s0, v20, v;
      r0 = rises; s0 = strobes;
      read_rb(20, v20);
      send(ch, 8'hEE);
      chk(bad_chan === 1'b1, "R5", "error pulse", int'(bad_chan), 1);
      chk(req_ready === 1'b1, "R5", "still ready", int'(req_ready), 1);
      @(negedge clk);
      chk(bad_chan === 1'b0, "R5", "error is one cycle", int'(bad_chan), 0);
      repeat (10) @(negedge clk);
      chk(rises == r0 && strobes == s0, "R5", "no serial activity",
          rises - r0 + strobes - s0, 0);
      read_rb(20, v);
      chk(v == v20, "R5", "readback untouched", v, v20);
      read_rb(ch, v);
      chk(v == 0, "R7", "out-of-range readback", v, 0);
   endtask

   task automatic t_held();
      int s0, v;
      phase_len = 8'd2; exp_len = 2;
      s0 = strobes;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_chan = 5'd3; req_val = 8'h96;
      @(negedge clk);
      req_chan = 5'd12; req_val = 8'h4B;
      chk(req_ready === 1'b0, "R6", "busy after accept", int'(req_ready), 0);
      while (!req_ready) @(negedge clk);
      chk(strobes == s0 + 1, "R6", "first frame done before second",
          strobes - s0, 1);
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready) @(negedge clk);
      chk(strobes == s0 + 2, "R6", "held request sent once", strobes - s0, 2);
      chk(frame_b == {3'd3, 8'h96} && sel_b == 2'd1, "R6", "first frame",
          int'(frame_b), int'({3'd3, 8'h96}));
      chk(frame_a == {3'd4, 8'h4B} && sel_a == 2'd2, "R6", "held frame",
          int'(frame_a), int'({3'd4, 8'h4B}));
      read_rb(12, v);
      chk(v == 8'h4B, "R7", "readback held frame", v, 8'h4B);
   endtask

   task automatic finish_up();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      bad++; total++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_frame(0, 8'hA5, 1);
      t_frame(7, 8'h3C, 2);
      t_frame(8, 8'hFF, 3);
      t_frame(15, 8'h01, 1);
      t_frame(16, 8'h80, 2);
      t_frame(20, 8'h5A, 0);
      t_frame(19, 8'h00, 1);
      t_bad(21);
      t_bad(31);
      t_held();
      finish_up();
   end
endmodule